// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host side of a parallel ATA multiword DMA burst for timing modes 0, 1 and 2. When the device raises its DMA request, the engine acknowledges with an active-low acknowledge and then issues a train of read or write strobes, one per 16-bit word. Words for a write burst come from a valid/ready input stream. Words from a read burst go out on a valid/ready output stream. The chip selects stay negated for the whole time.

A burst ends when the device drops its request between words or when the host raises a stop request. The engine always completes the word in flight and keeps the acknowledge asserted for the required hold time after the last strobe. A clock-period parameter turns the nanosecond limits of the selected mode into cycle counts. Mode and direction are latched when the burst starts. A word counter shows how many words the current or most recent burst has moved.

Top module: `mwdma_host`

## Requirements
- R1: While reset is high and after it is released with no request, dmack_n, dior_n and diow_n are high, dd_oe is 0, m_valid is 0 and word_cnt is 0.
- R2: In idle, with stop_req low, a high dmarq at a clock edge drives dmack_n low after that edge. No strobe is asserted in the first cycle that dmack_n is low.
- R3: Every strobe stays asserted for exactly ceil(tD/CLK_NS) cycles. tD is 215, 80 or 70 ns for modes 0, 1 and 2.
- R4: When the stream is never stalled, the negated time between two strobes of a burst is exactly max(ceil(tK/CLK_NS), ceil(t0/CLK_NS) - assertion cycles). t0 is 480/150/120 ns. tK is 50/50/25 ns for reads and 215/50/25 ns for writes. This stretches the negation until the cycle minimum holds.
- R5: Mode code 3 uses the mode 0 timing.
- R6: In a write burst (wr_dir=1), the strobe is diow_n. A word is taken from the input stream (s_valid and s_ready both high) in the cycle before its strobe asserts. It is driven on dd_out and held stable while the strobe is low. dd_oe is high while dmack_n is low.
- R7: In a read burst (wr_dir=0), the strobe is dior_n and dd_oe stays 0. dd_in is captured at the clock edge that ends the strobe. From that edge it appears on m_data with m_valid high, until m_ready is seen high.
- R8: A strobe starts only while dmarq is high and a word can move. For a write this means s_valid is high. For a read it means the output register is empty or being drained. Otherwise the engine waits with dmack_n low and both strobes negated.
- R9: If dmarq is low when the engine is between words, no further strobe starts. dmack_n returns high only after it has stayed low for at least max(1, ceil(tJ/CLK_NS)) cycles with the strobes negated. tJ is 20/5/5 ns.
- R10: A stop_req raised during a strobe lets that word finish, then ends the burst as in R9 even though dmarq stays high. While stop_req stays high in idle, no new burst starts.
- R11: word_cnt is cleared when a burst starts and increases by one as each strobe completes. After the burst it holds the number of words moved.
- R12: cs_n stays 2'b11. The read and write strobes are never low together, and neither is low unless dmack_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS ns |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Timing mode 0..2 (3 acts as 0), latched at burst start |
| wr_dir | input | 1 | 1 = host writes to device, 0 = host reads; latched at burst start |
| stop_req | input | 1 | Host request to end the burst after the current word |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, held negated |
| dd_in | input | DATA_W | Data bus from device |
| dd_out | output | DATA_W | Data bus toward device |
| dd_oe | output | 1 | Output enable for dd_out |
| s_valid | input | 1 | Write stream word valid |
| s_data | input | DATA_W | Write stream word |
| s_ready | output | 1 | Write stream word accepted |
| m_valid | output | 1 | Read stream word valid |
| m_data | output | DATA_W | Read stream word |
| m_ready | input | 1 | Read stream consumer ready |
| word_cnt | output | WCNT_W | Words moved in the current or last burst |

## Verification
The checker assumes that the device lowers dmarq only between words, and that dd_in is stable on the edge that ends a read strobe. It also assumes that s_data does not change while s_valid waits for s_ready. The stimulus changes every input on the falling clock edge. The device model updates dd_in when a strobe starts and drops dmarq right after the final strobe negates. The write source advances s_data only after the engine has shown the word on dd_out.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    localparam int MW_CNT_W = 12;
    typedef logic [MW_CNT_W-1:0] mw_cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_STROBE,
        ST_RECOV,
        ST_HOLD
    } mw_state_e;

    // Cycle counts that govern one burst
    typedef struct packed {
        mw_cnt_t act;   // strobe asserted cycles
        mw_cnt_t neg;   // minimum strobe negated cycles
        mw_cnt_t hold;  // acknowledge hold cycles after last strobe
    } mw_timing_t;

    function automatic int mw_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic mw_timing_t mw_calc(input logic [1:0] mode, input logic wr,
                                           input int clk_ns);
        int t0, td, tk, tj, a, n, h;
        case (mode)
            2'd1: begin t0 = 150; td = 80; tk = 50;               tj = 5;  end
            2'd2: begin t0 = 120; td = 70; tk = 25;               tj = 5;  end
            default: begin t0 = 480; td = 215; tk = wr ? 215 : 50; tj = 20; end
        endcase
        a = mw_ceil(td, clk_ns);
        n = mw_ceil(tk, clk_ns);
        if (mw_ceil(t0, clk_ns) - a > n) n = mw_ceil(t0, clk_ns) - a;
        h = mw_ceil(tj, clk_ns);
        if (h < 1) h = 1;
        mw_calc.act  = mw_cnt_t'(a);
        mw_calc.neg  = mw_cnt_t'(n);
        mw_calc.hold = mw_cnt_t'(h);
    endfunction

endpackage

// File: rtl/mwdma_seq.sv
module mwdma_seq
    import mwdma_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int WCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              wr_dir,
    input  logic              dmarq,
    input  logic              stop_req,
    input  logic              word_ok,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic              strobe_start,
    output logic              strobe_end,
    output logic              dir_q,
    output logic [WCNT_W-1:0] word_cnt
);

    mw_state_e  state;
    mw_cnt_t    cnt;
    mw_timing_t tq;
    logic       stop_q;
    logic       stop_any;

    assign stop_any     = stop_q || stop_req;
    assign strobe_start = (state == ST_ACK) && dmarq && !stop_any && word_ok;
    assign strobe_end   = (state == ST_STROBE) && (cnt == '0);
    assign dmack_n      = (state == ST_IDLE);
    assign dior_n       = !((state == ST_STROBE) && !dir_q);
    assign diow_n       = !((state == ST_STROBE) && dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            tq       <= '0;
            dir_q    <= 1'b0;
            stop_q   <= 1'b0;
            word_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    stop_q <= 1'b0;
                    if (dmarq && !stop_req) begin
                        state    <= ST_ACK;
                        tq       <= mw_calc(mode, wr_dir, CLK_NS);
                        dir_q    <= wr_dir;
                        word_cnt <= '0;
                    end
                end
                ST_ACK: begin
                    stop_q <= stop_any;
                    if (strobe_start) begin
                        state <= ST_STROBE;
                        cnt   <= tq.act - mw_cnt_t'(1);
                    end else if (stop_any || !dmarq) begin
                        state <= ST_HOLD;
                        cnt   <= tq.hold - mw_cnt_t'(1);
                    end
                end
                ST_STROBE: begin
                    stop_q <= stop_any;
                    if (cnt == '0) begin
                        word_cnt <= word_cnt + 1'b1;
                        if (tq.neg > mw_cnt_t'(1)) begin
                            state <= ST_RECOV;
                            cnt   <= tq.neg - mw_cnt_t'(2);
                        end else begin
                            state <= ST_ACK;
                        end
                    end else begin
                        cnt <= cnt - mw_cnt_t'(1);
                    end
                end
                ST_RECOV: begin
                    stop_q <= stop_any;
                    if (cnt == '0) state <= ST_ACK;
                    else           cnt   <= cnt - mw_cnt_t'(1);
                end
                ST_HOLD: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - mw_cnt_t'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mwdma_data.sv
module mwdma_data #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_q,
    input  logic              active,
    input  logic              strobe_start,
    input  logic              strobe_end,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              m_ready,
    input  logic [DATA_W-1:0] dd_in,
    output logic              word_ok,
    output logic              s_ready,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data
);

    assign word_ok = dir_q ? s_valid : (!m_valid || m_ready);
    assign s_ready = strobe_start && dir_q;
    assign dd_oe   = active && dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dd_out  <= '0;
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            if (strobe_start && dir_q) dd_out <= s_data;
            if (strobe_end && !dir_q) begin
                m_valid <= 1'b1;
                m_data  <= dd_in;
            end else if (m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mwdma_host.sv
module mwdma_host #(
    parameter int CLK_NS = 10,
    parameter int DATA_W = 16,
    parameter int WCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              wr_dir,
    input  logic              stop_req,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [1:0]        cs_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready,
    output logic [WCNT_W-1:0] word_cnt
);

    logic word_ok, strobe_start, strobe_end, dir_q;

    assign cs_n = '1;

    mwdma_seq #(.CLK_NS(CLK_NS), .WCNT_W(WCNT_W)) u_seq (
        .clk(clk), .rst(rst), .mode(mode), .wr_dir(wr_dir), .dmarq(dmarq),
        .stop_req(stop_req), .word_ok(word_ok), .dmack_n(dmack_n),
        .dior_n(dior_n), .diow_n(diow_n), .strobe_start(strobe_start),
        .strobe_end(strobe_end), .dir_q(dir_q), .word_cnt(word_cnt)
    );

    mwdma_data #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst(rst), .dir_q(dir_q), .active(!dmack_n),
        .strobe_start(strobe_start), .strobe_end(strobe_end),
        .s_valid(s_valid), .s_data(s_data), .m_ready(m_ready), .dd_in(dd_in),
        .word_ok(word_ok), .s_ready(s_ready), .dd_out(dd_out), .dd_oe(dd_oe),
        .m_valid(m_valid), .m_data(m_data)
    );

endmodule

// File: rtl/mwdma_host_chk.sv
module mwdma_host_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              dmarq,
    input logic              dmack_n,
    input logic              dior_n,
    input logic              diow_n,
    input logic              s_valid,
    input logic [DATA_W-1:0] dd_in,
    input logic [DATA_W-1:0] dd_out,
    input logic              m_valid,
    input logic [DATA_W-1:0] m_data
);

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    p_strobe_under_ack_r12: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> !dmack_n);

    p_no_strobe_first_ack_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(dmack_n) |-> (dior_n && diow_n));

    p_wr_needs_word_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(diow_n) |-> $past(s_valid));

    p_start_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(diow_n) || $fell(dior_n)) |-> $past(dmarq));

    p_rd_capture_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(dior_n) |-> (m_valid && m_data == $past(dd_in)));

    p_wr_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!diow_n && $past(!diow_n)) |-> $stable(dd_out));

    p_release_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(dmack_n) |-> $past(dior_n && diow_n));

endmodule

bind mwdma_host mwdma_host_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .dmarq(dmarq), .dmack_n(dmack_n), .dior_n(dior_n),
    .diow_n(diow_n), .s_valid(s_valid), .dd_in(dd_in), .dd_out(dd_out),
    .m_valid(m_valid), .m_data(m_data)
);

// File: tb/mwdma_host_test.sv
module mwdma_host_test;

    localparam int CLK_NS = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_i = 2'd0;
    logic wr_dir = 1'b0, stop_req = 1'b0, dmarq = 1'b0;
    logic [DW-1:0] dd_in = '0, s_data = '0;
    logic s_valid = 1'b0, m_ready = 1'b0;
    logic dmack_n, dior_n, diow_n, dd_oe, s_ready, m_valid;
    logic [1:0] cs_n;
    logic [DW-1:0] dd_out, m_data;
    logic [15:0] word_cnt;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    mwdma_host #(.CLK_NS(CLK_NS), .DATA_W(DW), .WCNT_W(16)) uut (
        .clk(clk), .rst(rst), .mode(mode_i), .wr_dir(wr_dir), .stop_req(stop_req),
        .dmarq(dmarq), .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .cs_n(cs_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .m_valid(m_valid),
        .m_data(m_data), .m_ready(m_ready), .word_cnt(word_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic int exp_act(input int md);
        int em = (md == 3) ? 0 : md;
        return cdiv(em == 0 ? 215 : (em == 1 ? 80 : 70));
    endfunction

    function automatic int exp_neg(input int md, input bit wr);
        int em = (md == 3) ? 0 : md;
        int t0 = (em == 0) ? 480 : (em == 1 ? 150 : 120);
        int tk = (em == 2) ? 25 : ((em == 0 && wr) ? 215 : 50);
        int n = cdiv(tk);
        if (cdiv(t0) - exp_act(md) > n) n = cdiv(t0) - exp_act(md);
        return n;
    endfunction

    function automatic int exp_hold(input int md);
        int em = (md == 3) ? 0 : md;
        int h = cdiv(em == 0 ? 20 : 5);
        return (h < 1) ? 1 : h;
    endfunction

    // One full burst of nw words; ends by device drop or host stop
    task automatic burst(input int md, input bit wr, input int nw, input bit use_stop);
        int a_e = exp_act(md), n_e = exp_neg(md, wr), h_e = exp_hold(md);
        int run = 0, gap = 0, nstb = 0;
        bit stb, prevstb = 0, csok = 1, done = 0, held = 1;
        logic [15:0] wb = 16'hA000 + 16'(md * 256 + (wr ? 16 : 0));
        logic [15:0] rb = 16'h5000 + 16'(md * 256);
        mode_i = 2'(md); wr_dir = wr; s_valid = 1'b1; s_data = wb;
        m_ready = 1'b1; dd_in = rb; dmarq = 1'b1;
        @(negedge clk);
        chk(dmack_n == 1'b0, "R2", "dmack one edge after request", int'(dmack_n), 0);
        chk(dior_n && diow_n, "R2", "strobes on first ack cycle", int'(dior_n & diow_n), 1);
        chk(word_cnt == 0, "R11", "count cleared at start", int'(word_cnt), 0);
        for (int guard = 0; guard < 4000 && !done; guard++) begin
            stb = !dior_n || !diow_n;
            if (cs_n != 2'b11 || (!dior_n && !diow_n)) csok = 0;
            if (stb && !prevstb) begin
                chk(nstb < nw, use_stop ? "R10" : "R9", "extra strobe", nstb, nw - 1);
                if (nstb > 0) chk(gap == n_e, "R4", "negation cycles", gap, n_e);
                if (wr) begin
                    chk(!diow_n, "R6", "write strobe used", int'(diow_n), 0);
                    chk(dd_out == wb + 16'(nstb), "R6", "write word", int'(dd_out), int'(wb) + nstb);
                    chk(dd_oe, "R6", "bus driven", int'(dd_oe), 1);
                    s_data = wb + 16'(nstb + 1);
                end else begin
                    chk(!dior_n, "R7", "read strobe used", int'(dior_n), 0);
                    chk(!dd_oe, "R7", "bus released", int'(dd_oe), 0);
                    dd_in = rb + 16'(nstb);
                end
                if (use_stop && nstb == nw - 1) stop_req = 1'b1;
                run = 1;
            end else if (stb) begin
                run++;
            end else if (prevstb) begin
                chk(run == a_e, md == 3 ? "R5" : "R3", "assertion cycles", run, a_e);
                if (!wr) chk(m_valid && m_data == rb + 16'(nstb), "R7", "read word",
                             int'(m_data), int'(rb) + nstb);
                nstb++;
                gap = 1;
                if (!use_stop && nstb == nw) dmarq = 1'b0;
            end else begin
                gap++;
            end
            if (dmack_n && nstb > 0) done = 1;
            prevstb = stb;
            if (!done) @(negedge clk);
        end
        chk(done, "R9", "burst released", int'(done), 1);
        chk(nstb == nw, use_stop ? "R10" : "R9", "words in burst", nstb, nw);
        chk(gap - 1 >= h_e, "R9", "ack hold cycles", gap - 1, h_e);
        chk(word_cnt == 16'(nw), "R11", "final count", int'(word_cnt), nw);
        chk(csok, "R12", "chip selects and strobe exclusivity", int'(csok), 1);
        if (use_stop) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (!dmack_n) held = 0;
            end
            chk(held, "R10", "no restart while stop held", int'(held), 1);
            stop_req = 1'b0;
        end
        dmarq = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_starts(input int n, inout int starts);
        bit prev;
        prev = !dior_n || !diow_n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((!dior_n || !diow_n) && !prev) starts++;
            prev = !dior_n || !diow_n;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int starts;
        bit held;
        repeat (3) @(negedge clk);
        chk(dmack_n && dior_n && diow_n, "R1", "control lines in reset", 0, 0);
        chk(!dd_oe && !m_valid && word_cnt == 0, "R1", "data side in reset", int'(word_cnt), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(dmack_n && dior_n && diow_n && !m_valid, "R1", "idle after reset", int'(dmack_n), 1);

        // Sweep every mode code in both directions, device-terminated
        for (int md = 0; md < 4; md++)
            for (int wr = 0; wr < 2; wr++)
                burst(md, wr[0], 3 + md, 1'b0);

        // Host stop during the last word
        burst(1, 1'b1, 3, 1'b1);
        burst(2, 1'b0, 2, 1'b1);

        // Idle with stop held: no burst starts (R10)
        stop_req = 1'b1; dmarq = 1'b1;
        held = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!dmack_n) held = 0;
        end
        chk(held, "R10", "stop blocks start in idle", int'(held), 1);
        stop_req = 1'b0; dmarq = 1'b0;
        repeat (2) @(negedge clk);

        // Write flow control: no word, no strobe (R8)
        mode_i = 2'd2; wr_dir = 1'b1; s_valid = 1'b0; dmarq = 1'b1;
        starts = 0;
        count_starts(8, starts);
        chk(starts == 0 && !dmack_n, "R8", "wait for write word", starts, 0);
        s_valid = 1'b1; s_data = 16'h1234;
        @(negedge clk);
        chk(!diow_n && dd_out == 16'h1234, "R8", "strobe once word valid", int'(dd_out), 16'h1234);
        s_valid = 1'b0; dmarq = 1'b0;
        starts = 1;
        count_starts(40, starts);
        chk(starts == 1 && dmack_n, "R8", "single write word moved", starts, 1);

        // Read flow control: full output register stalls (R8)
        mode_i = 2'd2; wr_dir = 1'b0; m_ready = 1'b0; dd_in = 16'h0BEE; dmarq = 1'b1;
        starts = 0;
        count_starts(40, starts);
        chk(starts == 1, "R8", "stall on full read register", starts, 1);
        chk(m_valid && m_data == 16'h0BEE, "R7", "read word held until taken", int'(m_data), 16'h0BEE);
        dmarq = 1'b0; m_ready = 1'b1;
        count_starts(20, starts);
        chk(starts == 1 && dmack_n && !m_valid, "R8", "no strobe after drop", starts, 1);
        chk(word_cnt == 1, "R11", "count after stalled read", int'(word_cnt), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule